// File: doc/BRIEF.md
# Verified Result Reuse Cache

This block sits beside the issue stage of a core that runs every instruction twice to catch transient faults. It remembers a small set of instructions whose two executions have already agreed. Each remembered instruction is stored as its opcode, its two operand values and its result. When the primary copy of an instruction executes, the block is probed with the opcode and both operands. A hit returns the remembered result, which then serves as the check value, so the second copy does not need an issue slot. A miss raises a request for the normal redundant issue.

New results enter through a separate insert port. A result is accepted only when the caller marks it as agreed by both executions. An insert whose key is already held rewrites that entry's result in place. Any other accepted insert takes the slot named by a rotating pointer. A synchronous clear drops every entry at once.

Top module: `reuse_buf`

## Requirements
- R1: While reset is asserted, and after it is released, no entry is valid: a probe with the probe-valid input high gives hit 0 and redundant-issue request 1.
- R2: A probe hits only when a valid entry matches the opcode, the first operand and the second operand, each in its own position. Swapping the two operands or changing the opcode misses. On a hit the result output equals the stored result.
- R3: With the probe-valid input high, the redundant-issue request is the inverse of hit. With the probe-valid input low, hit and the request are both 0.
- R4: An insert whose agreed flag is 0 changes no entry. A later probe of that key still misses.
- R5: The probe is combinational against the stored state. An insert becomes visible to probes from the cycle after it is accepted. A probe of the same key in the same cycle as the insert misses.
- R6: An accepted insert whose key matches a valid entry updates that entry's result and allocates no new slot. At most one entry ever matches a key.
- R7: An accepted insert of a new key writes the slot under a rotating pointer and advances the pointer by one, wrapping after ENTRIES slots. With ENTRIES = 8, the ninth distinct key evicts the first and the other seven keys remain.
- R8: The clear input invalidates every entry and returns the pointer to slot 0. It takes priority over an insert in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous invalidate of all entries |
| lk_valid_i | input | 1 | Probe request |
| lk_opc_i | input | OPC_W | Probe opcode |
| lk_a_i | input | DATA_W | Probe first operand |
| lk_b_i | input | DATA_W | Probe second operand |
| lk_hit_o | output | 1 | Probe matched a verified entry |
| lk_result_o | output | DATA_W | Stored result on a hit, zero otherwise |
| lk_redo_o | output | 1 | Redundant issue required |
| ins_valid_i | input | 1 | Insert request |
| ins_ok_i | input | 1 | Both executions agreed |
| ins_opc_i | input | OPC_W | Insert opcode |
| ins_a_i | input | DATA_W | Insert first operand |
| ins_b_i | input | DATA_W | Insert second operand |
| ins_result_i | input | DATA_W | Verified result |

## Verification
A wrong valid bit or key shows up as a false hit or a false miss on the very next probe of the affected key. A false hit is the serious case, because it skips a check the core needs. A pointer that advances wrongly, or an update that allocates a duplicate, shows no symptom until the pointer wraps. The error then appears as the wrong key being evicted up to ENTRIES inserts later. For that reason the sequences fill the buffer past one full wrap and probe both the evicted key and the surviving keys.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int unsigned RB_ENTRIES = 8;
  localparam int unsigned RB_OPC_W   = 8;
  localparam int unsigned RB_DATA_W  = 32;

  function automatic int unsigned rb_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rb_match.sv
module rb_match #(
  parameter int unsigned ENTRIES = rb_pkg::RB_ENTRIES,
  parameter int unsigned KEY_W   = 72
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][KEY_W-1:0] keys_i,
  input  logic [KEY_W-1:0]              probe_i,
  output logic [ENTRIES-1:0]            match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (keys_i[g] == probe_i);
  end
endmodule

// File: rtl/rb_victim.sv
module rb_victim #(
  parameter int unsigned ENTRIES = rb_pkg::RB_ENTRIES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic adv_i,
  output logic [rb_pkg::rb_idx_w(ENTRIES)-1:0] ptr_o
);
  localparam int unsigned IDX_W = rb_pkg::rb_idx_w(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr_i)      ptr_d = '0;
    else if (adv_i) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/rb_store.sv
module rb_store #(
  parameter int unsigned ENTRIES = rb_pkg::RB_ENTRIES,
  parameter int unsigned KEY_W   = 72,
  parameter int unsigned DATA_W  = rb_pkg::RB_DATA_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr_i,
  input  logic                           wr_en_i,
  input  logic [rb_pkg::rb_idx_w(ENTRIES)-1:0] wr_idx_i,
  input  logic [KEY_W-1:0]               wr_key_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [ENTRIES-1:0]             valid_o,
  output logic [ENTRIES-1:0][KEY_W-1:0]  keys_o,
  output logic [ENTRIES-1:0][DATA_W-1:0] data_o
);
  logic [ENTRIES-1:0]             valid_q, valid_d;
  logic [ENTRIES-1:0][KEY_W-1:0]  key_q;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q;
  logic                           wr_go;

  assign wr_go = wr_en_i && !clr_i;

  always_comb begin
    valid_d = valid_q;
    if (clr_i)      valid_d = '0;
    else if (wr_en_i) valid_d[wr_idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      key_q[wr_idx_i]  <= wr_key_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign valid_o = valid_q;
  assign keys_o  = key_q;
  assign data_o  = data_q;

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (valid_q == '0));

  assert_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> ($countones(valid_q) >= $past($countones(valid_q))));

  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !clr_i) |=> $stable(valid_q));
endmodule

// File: rtl/reuse_buf.sv
module reuse_buf #(
  parameter int unsigned ENTRIES = rb_pkg::RB_ENTRIES,
  parameter int unsigned OPC_W   = rb_pkg::RB_OPC_W,
  parameter int unsigned DATA_W  = rb_pkg::RB_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              lk_valid_i,
  input  logic [OPC_W-1:0]  lk_opc_i,
  input  logic [DATA_W-1:0] lk_a_i,
  input  logic [DATA_W-1:0] lk_b_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_result_o,
  output logic              lk_redo_o,
  input  logic              ins_valid_i,
  input  logic              ins_ok_i,
  input  logic [OPC_W-1:0]  ins_opc_i,
  input  logic [DATA_W-1:0] ins_a_i,
  input  logic [DATA_W-1:0] ins_b_i,
  input  logic [DATA_W-1:0] ins_result_i
);
  localparam int unsigned KEY_W = OPC_W + 2 * DATA_W;
  localparam int unsigned IDX_W = rb_pkg::rb_idx_w(ENTRIES);

  logic [ENTRIES-1:0]             valid;
  logic [ENTRIES-1:0][KEY_W-1:0]  keys;
  logic [ENTRIES-1:0][DATA_W-1:0] data;
  logic [ENTRIES-1:0]             lk_match, ins_match;
  logic [KEY_W-1:0]               lk_key, ins_key;
  logic [IDX_W-1:0]               ptr, hit_idx, wr_idx;
  logic                           ins_fire, ins_hit, alloc;
  logic [DATA_W-1:0]              lk_res;

  assign lk_key  = {lk_opc_i, lk_a_i, lk_b_i};
  assign ins_key = {ins_opc_i, ins_a_i, ins_b_i};

  rb_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_lk_match (
    .valid_i(valid), .keys_i(keys), .probe_i(lk_key), .match_o(lk_match));

  rb_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_ins_match (
    .valid_i(valid), .keys_i(keys), .probe_i(ins_key), .match_o(ins_match));

  assign ins_fire = ins_valid_i && ins_ok_i;
  assign ins_hit  = |ins_match;
  assign alloc    = ins_fire && !ins_hit && !clr_i;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (ins_match[i]) hit_idx = hit_idx | IDX_W'(i);
  end

  assign wr_idx = ins_hit ? hit_idx : ptr;

  rb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .adv_i(alloc), .ptr_o(ptr));

  rb_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .wr_en_i(ins_fire),
    .wr_idx_i(wr_idx), .wr_key_i(ins_key), .wr_data_i(ins_result_i),
    .valid_o(valid), .keys_o(keys), .data_o(data));

  always_comb begin
    lk_res = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) lk_res = lk_res | data[i];
  end

  assign lk_hit_o    = lk_valid_i && (|lk_match);
  assign lk_result_o = lk_hit_o ? lk_res : '0;
  assign lk_redo_o   = lk_valid_i && !(|lk_match);

  assert_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match) && $onehot0(ins_match));

  assert_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_ok_i && !clr_i) |=> $stable(valid));
endmodule

// File: tb/reuse_buf_bench.sv
module reuse_buf_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, clr_i, lk_valid_i, ins_valid_i, ins_ok_i;
  logic [7:0]  lk_opc_i, ins_opc_i;
  logic [31:0] lk_a_i, lk_b_i, ins_a_i, ins_b_i, ins_result_i, lk_result_o;
  logic        lk_hit_o, lk_redo_o;

  reuse_buf u_reuse_buf (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .lk_valid_i(lk_valid_i),
    .lk_opc_i(lk_opc_i), .lk_a_i(lk_a_i), .lk_b_i(lk_b_i),
    .lk_hit_o(lk_hit_o), .lk_result_o(lk_result_o), .lk_redo_o(lk_redo_o),
    .ins_valid_i(ins_valid_i), .ins_ok_i(ins_ok_i), .ins_opc_i(ins_opc_i),
    .ins_a_i(ins_a_i), .ins_b_i(ins_b_i), .ins_result_i(ins_result_i));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          mv [N];
  logic [71:0] mk [N];
  logic [31:0] md [N];
  int          mptr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int model_find(input logic [71:0] k);
    for (int i = 0; i < N; i++) if (mv[i] && mk[i] == k) return i;
    return -1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++) mv[i] = 0;
    mptr = 0;
  endtask

  task automatic step(input string tag, input logic lv, input logic [7:0] lo,
                      input logic [31:0] la, input logic [31:0] lb,
                      input logic iv, input logic [7:0] io, input logic [31:0] ia,
                      input logic [31:0] ib, input logic [31:0] ir,
                      input logic ok, input logic cl);
    int f;
    lk_valid_i = lv; lk_opc_i = lo; lk_a_i = la; lk_b_i = lb;
    ins_valid_i = iv; ins_opc_i = io; ins_a_i = ia; ins_b_i = ib;
    ins_result_i = ir; ins_ok_i = ok; clr_i = cl;
    #1;
    f = lv ? model_find({lo, la, lb}) : -1;
    chk(tag, 32'(lk_hit_o), 32'(f >= 0));
    chk(tag, 32'(lk_redo_o), 32'(lv && f < 0));
    if (f >= 0) chk(tag, lk_result_o, md[f]);
    @(posedge clk);
    if (cl) model_clear();
    else if (iv && ok) begin
      f = model_find({io, ia, ib});
      if (f >= 0) md[f] = ir;
      else begin
        mv[mptr] = 1; mk[mptr] = {io, ia, ib}; md[mptr] = ir;
        mptr = (mptr + 1) % N;
      end
    end
    @(negedge clk);
  endtask

  task automatic ins(input string tag, input int k, input logic [31:0] r, input logic ok);
    step(tag, 0, 0, 0, 0, 1, 8'(16 + k), 32'(k), 32'(k + 100), r, ok, 0);
  endtask

  task automatic look(input string tag, input int k);
    step(tag, 1, 8'(16 + k), 32'(k), 32'(k + 100), 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; clr_i = 0; lk_valid_i = 1; lk_opc_i = 8'h11; lk_a_i = 1; lk_b_i = 101;
    ins_valid_i = 0; ins_ok_i = 0; ins_opc_i = 0; ins_a_i = 0; ins_b_i = 0; ins_result_i = 0;
    model_clear();
    repeat (3) @(negedge clk);
    chk("R1 hit in reset", 32'(lk_hit_o), 0);
    chk("R1 redo in reset", 32'(lk_redo_o), 1);
    rst_n = 1;
    @(negedge clk);
    look("R1 after reset", 1);

    ins("R4 unverified insert", 1, 32'hAAAA, 0);
    look("R4 probe after reject", 1);

    step("R5 same-cycle probe", 1, 8'(17), 1, 101, 1, 8'(17), 1, 101, 32'h1111, 1, 0);
    look("R5 next-cycle probe", 1);
    step("R2 swapped operands", 1, 8'(17), 101, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R2 other opcode", 1, 8'(18), 1, 101, 0, 0, 0, 0, 0, 0, 0);
    step("R3 probe idle", 0, 8'(17), 1, 101, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 idle hit", 32'(lk_hit_o), 0);

    step("R8 clear beats insert", 0, 0, 0, 0, 1, 8'(25), 9, 109, 32'h9, 1, 1);
    look("R8 cleared key", 1);
    look("R8 blocked insert", 9);

    for (int k = 0; k < 4; k++) ins("R7 fill", k, 32'h100 + 32'(k), 1);
    ins("R6 update in place", 1, 32'hBEEF, 1);
    for (int k = 4; k < 8; k++) ins("R7 fill", k, 32'h100 + 32'(k), 1);
    look("R6 first key kept", 0);
    look("R6 updated result", 1);
    ins("R7 ninth key", 8, 32'h108, 1);
    look("R7 evicted key", 0);
    for (int k = 1; k < 9; k++) look("R7 survivors", k);

    for (int c = 0; c < 3000; c++) begin
      logic [7:0] o1, o2;
      logic [31:0] a1, b1, a2, b2;
      o1 = 8'($urandom % 4); a1 = $urandom % 4; b1 = $urandom % 4;
      o2 = 8'($urandom % 4); a2 = $urandom % 4; b2 = $urandom % 4;
      step("R2 R6 R7 random", 1'($urandom % 4 != 0), o1, a1, b1,
           1'($urandom % 2), o2, a2, b2, $urandom, 1'($urandom % 4 != 0),
           1'($urandom % 200 == 0));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule